// File: doc/BRIEF.md
# External Bus Strobe Generator

This block turns the machine-cycle phase of an 8-bit microcontroller core into the strobes that drive an external memory bus. The core's sequencer supplies a phase count of 0 to 11 on every oscillator clock. The block produces three outputs:

- an address-latch strobe, which pulses twice per machine cycle, so at one sixth of the oscillator rate;
- an active-low program-fetch strobe, which pulses twice per machine cycle while code runs from external memory;
- a select for the shared low address/data port, which shows the address while the latch strobe is high.

A machine cycle that moves data to or from external data memory drops one latch pulse and both fetch pulses. That leaves the bus free for the data transfer.

A register bit can switch the free-running latch strobe off. While it is off, the strobe stays at its idle high level. It still pulses in cycles that perform an external data move or a code-constant read. The same bit is ignored whenever the core executes from external program memory.

All outputs are registered. Each one reflects the phase and flags that were presented one oscillator clock earlier.

Top module: `bus_strobe_gen`

## Requirements
- R1: With no data move and the strobe enabled, `ale_o` is 1 in the clock after phase 0, 1, 6 or 7 is presented and 0 after every other phase. This gives two pulses of two clocks in each 12-clock cycle.
- R2: In a cycle with `xdata_i`=1, the latch pulse for phases 0-1 is dropped (`ale_o`=0 there). The pulse for phases 6-7 is still issued.
- R3: With `ale_off_i`=1, `ext_exec_i`=0, `xdata_i`=0 and `code_rd_i`=0, `ale_o` holds 1 (idle high) after every phase.
- R4: With `ale_off_i`=1, a cycle with `code_rd_i`=1 or `xdata_i`=1 produces the normal pulse pattern of R1/R2.
- R5: With `ext_exec_i`=1, `ale_off_i` has no effect, and `ale_o` follows R1/R2.
- R6: With `ext_exec_i`=1 and `xdata_i`=0, `psen_no` is 0 in the clock after phase 3, 4, 9 or 10 and 1 otherwise. With `ext_exec_i`=0 it stays 1.
- R7: In a cycle with `xdata_i`=1, both fetch pulses are skipped (`psen_no` stays 1).
- R8: `port_addr_o` is 1 in the clock after each phase that carries a scheduled latch pulse (R1/R2), whether or not the strobe is suppressed. Otherwise it is 0 and the port carries the data or code byte.
- R9: While `rst_ni`=0: `ale_o`=0, `psen_no`=1, `port_addr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | $clog2(CYC_LEN) | Phase within the machine cycle, 0..CYC_LEN-1 |
| xdata_i | input | 1 | Current cycle performs an external data memory access |
| code_rd_i | input | 1 | Current instruction is a code-constant read |
| ext_exec_i | input | 1 | Core executes from external program memory |
| ale_off_i | input | 1 | Latch-strobe disable register bit |
| ale_o | output | 1 | Address latch strobe |
| psen_no | output | 1 | Program fetch strobe, active low |
| port_addr_o | output | 1 | 1: low port drives address; 0: data/code byte |

## Verification
Every output settles exactly one clock after the phase and flags that define it. The bench drives inputs on the falling edge. On each falling edge it first compares the outputs with the value expected for the inputs it drove one falling edge earlier, and only then drives the next phase. Expected values come from the slot numbers and the gating rules in the requirements. Each machine-cycle scenario is swept through all 12 phases, so a shifted slot, a wrong width or a missing skip shows up at the exact phase where it occurs.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

   typedef struct packed {
      logic xdata;
      logic code_rd;
      logic ext_exec;
      logic ale_off;
   } strobe_ctl_t;

   typedef struct packed {
      logic ale;
      logic psen_n;
      logic port_addr;
   } strobe_out_t;

   localparam strobe_out_t STROBE_RST = '{ale: 1'b0, psen_n: 1'b1, port_addr: 1'b0};

endpackage

// File: rtl/bus_strobe_phase_dec.sv
module bus_strobe_phase_dec #(
   parameter int CYC_LEN = 12,
   parameter int PULSE_W = 2,
   parameter int ALE_A   = 0,
   parameter int ALE_B   = 6,
   parameter int PSEN_A  = 3,
   parameter int PSEN_B  = 9,
   localparam int PH_W   = $clog2(CYC_LEN)
) (
   input  logic [PH_W-1:0] phase_i,
   output logic            ale_slot_a_o,
   output logic            ale_slot_b_o,
   output logic            psen_slot_o
);

   localparam int NSLOT = 4;
   localparam int SLOT_START [NSLOT] = '{ALE_A, ALE_B, PSEN_A, PSEN_B};

   logic [NSLOT-1:0] hit;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_comb begin
         int p;
         p = int'(phase_i);
         hit[s] = (p >= SLOT_START[s]) && (p < SLOT_START[s] + PULSE_W);
      end
   end

   assign ale_slot_a_o = hit[0];
   assign ale_slot_b_o = hit[1];
   assign psen_slot_o  = hit[2] | hit[3];

endmodule

// File: rtl/bus_strobe_gate.sv
module bus_strobe_gate
   import bus_strobe_pkg::*;
(
   input  strobe_ctl_t ctl_i,
   input  logic        ale_slot_a_i,
   input  logic        ale_slot_b_i,
   input  logic        psen_slot_i,
   output strobe_out_t out_o
);

   logic ale_sched;
   logic ale_drive;

   always_comb begin
      // R2: a data access cycle drops the first latch slot
      ale_sched = (ale_slot_a_i & ~ctl_i.xdata) | ale_slot_b_i;
      // R3/R4/R5: disable bit honoured only in internal execution outside moves
      ale_drive = ~ctl_i.ale_off | ctl_i.ext_exec | ctl_i.xdata | ctl_i.code_rd;
      out_o.ale       = ale_drive ? ale_sched : 1'b1;
      out_o.psen_n    = ~(psen_slot_i & ctl_i.ext_exec & ~ctl_i.xdata);
      out_o.port_addr = ale_sched;
   end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
   import bus_strobe_pkg::*;
#(
   parameter int CYC_LEN = 12,
   parameter int PULSE_W = 2,
   parameter int ALE_A   = 0,
   parameter int ALE_B   = 6,
   parameter int PSEN_A  = 3,
   parameter int PSEN_B  = 9,
   parameter bit OUT_REG = 1'b1,
   localparam int PH_W   = $clog2(CYC_LEN)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [PH_W-1:0] phase_i,
   input  logic            xdata_i,
   input  logic            code_rd_i,
   input  logic            ext_exec_i,
   input  logic            ale_off_i,
   output logic            ale_o,
   output logic            psen_no,
   output logic            port_addr_o
);

   // elaboration-time parameter checks
   if (CYC_LEN < 4)
      $error("CYC_LEN too small");
   if (PULSE_W < 1)
      $error("PULSE_W must be positive");
   if (ALE_A + PULSE_W > ALE_B || ALE_B + PULSE_W > CYC_LEN)
      $error("latch slots overlap or exceed the cycle");
   if (PSEN_A + PULSE_W > PSEN_B || PSEN_B + PULSE_W > CYC_LEN)
      $error("fetch slots overlap or exceed the cycle");

   strobe_ctl_t ctl;
   strobe_out_t nxt;
   strobe_out_t cur;
   logic        slot_a;
   logic        slot_b;
   logic        slot_p;

   assign ctl = '{xdata: xdata_i, code_rd: code_rd_i, ext_exec: ext_exec_i, ale_off: ale_off_i};

   bus_strobe_phase_dec #(
      .CYC_LEN (CYC_LEN),
      .PULSE_W (PULSE_W),
      .ALE_A   (ALE_A),
      .ALE_B   (ALE_B),
      .PSEN_A  (PSEN_A),
      .PSEN_B  (PSEN_B)
   ) i_dec (
      .phase_i      (phase_i),
      .ale_slot_a_o (slot_a),
      .ale_slot_b_o (slot_b),
      .psen_slot_o  (slot_p)
   );

   bus_strobe_gate i_gate (
      .ctl_i        (ctl),
      .ale_slot_a_i (slot_a),
      .ale_slot_b_i (slot_b),
      .psen_slot_i  (slot_p),
      .out_o        (nxt)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) cur <= STROBE_RST;
         else         cur <= nxt;
      end

      a_r6_psen_only_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !cur.psen_n |-> $past(ext_exec_i));
      a_r7_psen_skip_xdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !cur.psen_n |-> !$past(xdata_i));
      a_r8_addr_under_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cur.port_addr |-> cur.ale);
      a_r3_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(ale_off_i & ~ext_exec_i & ~xdata_i & ~code_rd_i) |-> cur.ale);
      a_r2_first_slot_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(xdata_i) && $past(phase_i) == PH_W'(ALE_A)) |-> !cur.port_addr);
      a_r5_ext_ignores_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(ext_exec_i) && $past(phase_i) == PH_W'(ALE_B)) |-> cur.ale);
   end else begin : g_comb
      assign cur = rst_ni ? nxt : STROBE_RST;
   end

   assign ale_o       = cur.ale;
   assign psen_no     = cur.psen_n;
   assign port_addr_o = cur.port_addr;

endmodule

// File: tb/test_bus_strobe_gen.sv
module test_bus_strobe_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] phase = 4'd11;
   logic       xdata = 1'b0, code_rd = 1'b0, ext_exec = 1'b0, ale_off = 1'b0;
   logic       ale, psen_n, port_addr;

   int n_chk = 0;
   int n_bad = 0;

   // inputs driven at the previous falling edge
   int   p_phase = 11;
   logic p_x = 0, p_c = 0, p_e = 0, p_o = 0;

   always #2.5 clk = ~clk;

   bus_strobe_gen i_bus_strobe_gen (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .phase_i     (phase),
      .xdata_i     (xdata),
      .code_rd_i   (code_rd),
      .ext_exec_i  (ext_exec),
      .ale_off_i   (ale_off),
      .ale_o       (ale),
      .psen_no     (psen_n),
      .port_addr_o (port_addr)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp, input int ph);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s after phase %0d: actual %b expected %b", req, what, ph, act, exp);
      end
   endtask

   // expected outputs for one set of inputs, from the requirements
   task automatic check_prev(input string req);
      logic sched, drive, e_ale, e_psen, e_port;
      sched  = (((p_phase == 0) || (p_phase == 1)) && !p_x) || (p_phase == 6) || (p_phase == 7);
      drive  = !p_o || p_e || p_x || p_c;
      e_ale  = drive ? sched : 1'b1;
      e_psen = !(p_e && !p_x && (p_phase == 3 || p_phase == 4 || p_phase == 9 || p_phase == 10));
      e_port = sched;
      chk(req, "ale_o", ale, e_ale, p_phase);
      chk(req, "psen_no", psen_n, e_psen, p_phase);
      chk(req, "port_addr_o", port_addr, e_port, p_phase);
   endtask

   // one machine cycle with fixed flags; each phase checks the preceding one
   task automatic run_cycle(input string req, input logic x, input logic c, input logic e, input logic o);
      for (int p = 0; p < 12; p++) begin
         @(negedge clk);
         check_prev(req);
         phase = 4'(p); xdata = x; code_rd = c; ext_exec = e; ale_off = o;
         p_phase = p; p_x = x; p_c = c; p_e = e; p_o = o;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R9", "ale_o", ale, 1'b0, -1);
      chk("R9", "psen_no", psen_n, 1'b1, -1);
      chk("R9", "port_addr_o", port_addr, 1'b0, -1);
      ext_exec = 1'b1; phase = 4'd3;
      @(negedge clk);
      chk("R9", "psen_no held", psen_n, 1'b1, 3);
      phase = 4'd11; ext_exec = 1'b0;
      rst_n = 1'b1;
      p_phase = 11; p_x = 0; p_c = 0; p_e = 0; p_o = 0;
   endtask

   task automatic t_internal;      run_cycle("R1", 0, 0, 0, 0); run_cycle("R1", 0, 0, 0, 0); endtask
   task automatic t_xdata_int;     run_cycle("R2", 1, 0, 0, 0); run_cycle("R8", 0, 0, 0, 0); endtask
   task automatic t_ale_off;       run_cycle("R3", 0, 0, 0, 1); run_cycle("R3", 0, 0, 0, 1); endtask
   task automatic t_off_moves;     run_cycle("R4", 0, 1, 0, 1); run_cycle("R4", 1, 0, 0, 1); run_cycle("R3", 0, 0, 0, 1); endtask
   task automatic t_ext_off;       run_cycle("R5", 0, 0, 1, 1); run_cycle("R5", 0, 0, 1, 0); endtask
   task automatic t_ext_fetch;     run_cycle("R6", 0, 0, 1, 0); run_cycle("R6", 0, 1, 1, 0); endtask
   task automatic t_ext_xdata;     run_cycle("R7", 1, 0, 1, 0); run_cycle("R7", 1, 0, 1, 1); run_cycle("R6", 0, 0, 1, 0); endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_internal();
      t_xdata_int();
      t_ale_off();
      t_off_moves();
      t_ext_off();
      t_ext_fetch();
      t_ext_xdata();
      run_cycle("R1", 0, 0, 0, 0);
      @(negedge clk);
      check_prev("R1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule